// File: doc/BRIEF.md
# Channel-Indexed Configuration Register Bank

This block holds the control settings of a four-channel converter behind a simple register port. A serial control front end decodes its frames into single-cycle write and read strobes with a 10-bit address and an 8-bit data byte, and the bank turns those strobes into stored settings. A write strobe stores the byte on the clock edge that samples it. A read strobe loads the addressed value into a registered output on that same edge.

Two kinds of register exist. A global register has a single copy. A local register has six copies: four for the data channels and two for the clock-output channels (frame clock and data clock). A channel index register at address 0x005 chooses which copies a local write reaches, so one write can program several channels at once. A local read returns exactly one copy. Reset loads every defined register with its default value. Addresses outside the map cannot be written and read back as zero.

Top module: `chanRegBank`

## Requirements
- R1: After reset, address 0x005 reads 0x3F, local 0x00D reads 0x00, local 0x014 reads 0x01, local 0x100 reads 0x05 in every channel copy, global 0x008 reads 0x00 and global 0x109 reads 0x02.
- R2: `rdData` takes the addressed value on the clock edge that samples `rdEn` high, and keeps its value on every edge where `rdEn` is low.
- R3: The index register is at address 0x005 and stores bits [5:0]. Bits 0, 1, 2 and 3 select data channels A, B, C and D, bit 4 selects the frame-clock channel and bit 5 selects the data-clock channel. Bits [7:6] always read 0.
- R4: A write to a local address updates the copy of every channel whose index bit is set, and leaves the copies of channels whose bit is clear unchanged. With 0x3F all six copies are updated.
- R5: A read of a local address returns the copy of the selected channel when exactly one index bit is set. When several index bits are set, or none, it returns the channel A copy.
- R6: Global addresses 0x008 and 0x109 hold one copy each, and the index register value changes neither what a write to them stores nor what a read returns.
- R7: Bits outside a register's used field are stored and read as 0. The used fields are 0x00D [5:0], 0x014 [7:0], 0x100 [3:0], 0x008 [7:0], 0x109 [2:0] and 0x005 [5:0].
- R8: A write to an address outside the map changes no register, and a read of such an address returns 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rstN | input | 1 | Active-low synchronous reset, loads the defaults |
| wrEn | input | 1 | Write strobe, one cycle per write |
| rdEn | input | 1 | Read strobe, one cycle per read |
| addr | input | 10 | Register address |
| wrData | input | 8 | Byte to write |
| rdData | output | 8 | Registered read result, valid after the edge that samples rdEn |

## Verification
The hardest case to reach from the ports is showing that one local write reached some channel copies and left the others alone. Every copy can only be seen through the index register, and a read with several bits set always falls back to channel A. The stimulus therefore writes a local address under a multi-bit or clock-only index. It then rewrites the index to each single channel in turn and reads the address back, so every copy is brought to the output one at a time. The clock-channel copies are reached only through a one-hot index with bit 4 or bit 5 set.

// File: rtl/chanRegPkg.sv
package chanRegPkg;
  localparam int ADDR_W   = 10;
  localparam int DATA_W   = 8;
  localparam int NUM_DATA = 4;
  localparam int NUM_CLK  = 2;
  localparam int NUM_CH   = NUM_DATA + NUM_CLK;
  localparam int CH_W     = $clog2(NUM_CH);
  localparam int NUM_LOC  = 3;
  localparam int NUM_GLB  = 2;

  localparam logic [ADDR_W-1:0] IDX_ADDR = 10'h005;
  localparam logic [DATA_W-1:0] IDX_DFLT = 8'h3F;

  // entry 0 is the rightmost element
  localparam logic [NUM_LOC-1:0][ADDR_W-1:0] LOC_ADDR = {10'h100, 10'h014, 10'h00D};
  localparam logic [NUM_LOC-1:0][DATA_W-1:0] LOC_MASK = {8'h0F, 8'hFF, 8'h3F};
  localparam logic [NUM_LOC-1:0][DATA_W-1:0] LOC_DFLT = {8'h05, 8'h01, 8'h00};

  localparam logic [NUM_GLB-1:0][ADDR_W-1:0] GLB_ADDR = {10'h109, 10'h008};
  localparam logic [NUM_GLB-1:0][DATA_W-1:0] GLB_MASK = {8'h07, 8'hFF};
  localparam logic [NUM_GLB-1:0][DATA_W-1:0] GLB_DFLT = {8'h02, 8'h00};

  typedef struct packed {
    logic               wrIdx;
    logic [NUM_GLB-1:0] wrGlb;
    logic [NUM_LOC-1:0] wrLoc;
    logic               rdStb;
    logic               rdIdx;
    logic [NUM_GLB-1:0] rdGlb;
    logic [NUM_LOC-1:0] rdLoc;
  } regStrobes_t;
endpackage

// File: rtl/chanRegCtrl.sv
module chanRegCtrl
  import chanRegPkg::*;
(
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output regStrobes_t       strobes
);
  logic               hitIdx;
  logic [NUM_GLB-1:0] hitGlb;
  logic [NUM_LOC-1:0] hitLoc;

  assign hitIdx = (addr == IDX_ADDR);

  for (genvar g = 0; g < NUM_GLB; g++) begin : gGlbDec
    assign hitGlb[g] = (addr == GLB_ADDR[g]);
  end

  for (genvar l = 0; l < NUM_LOC; l++) begin : gLocDec
    assign hitLoc[l] = (addr == LOC_ADDR[l]);
  end

  always_comb begin
    strobes.wrIdx = wrEn & hitIdx;
    strobes.wrGlb = {NUM_GLB{wrEn}} & hitGlb;
    strobes.wrLoc = {NUM_LOC{wrEn}} & hitLoc;
    strobes.rdStb = rdEn;
    strobes.rdIdx = rdEn & hitIdx;
    strobes.rdGlb = {NUM_GLB{rdEn}} & hitGlb;
    strobes.rdLoc = {NUM_LOC{rdEn}} & hitLoc;
  end
endmodule

// File: rtl/chanRegData.sv
module chanRegData
  import chanRegPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  regStrobes_t       strobes,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  logic [NUM_CH-1:0] idxReg;
  logic [DATA_W-1:0] glbReg [NUM_GLB];
  logic [DATA_W-1:0] locReg [NUM_LOC][NUM_CH];
  logic [CH_W-1:0]   rdChan;
  logic [DATA_W-1:0] rdNext;

  always_ff @(posedge clk) begin
    if (!rstN)              idxReg <= IDX_DFLT[NUM_CH-1:0];
    else if (strobes.wrIdx) idxReg <= wrData[NUM_CH-1:0];
  end

  for (genvar g = 0; g < NUM_GLB; g++) begin : gGlbReg
    always_ff @(posedge clk) begin
      if (!rstN)                 glbReg[g] <= GLB_DFLT[g];
      else if (strobes.wrGlb[g]) glbReg[g] <= wrData & GLB_MASK[g];
    end
  end

  for (genvar l = 0; l < NUM_LOC; l++) begin : gLocReg
    for (genvar c = 0; c < NUM_CH; c++) begin : gChan
      always_ff @(posedge clk) begin
        if (!rstN)                              locReg[l][c] <= LOC_DFLT[l];
        else if (strobes.wrLoc[l] && idxReg[c]) locReg[l][c] <= wrData & LOC_MASK[l];
      end
    end
  end

  // one-hot index picks its channel, anything else falls back to channel A
  always_comb begin
    rdChan = '0;
    if ($countones(idxReg) == 1) begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (idxReg[c]) rdChan = CH_W'(c);
      end
    end
  end

  always_comb begin
    rdNext = '0;
    if (strobes.rdIdx) rdNext = DATA_W'(idxReg);
    for (int g = 0; g < NUM_GLB; g++) begin
      if (strobes.rdGlb[g]) rdNext = glbReg[g];
    end
    for (int l = 0; l < NUM_LOC; l++) begin
      if (strobes.rdLoc[l]) rdNext = locReg[l][rdChan];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)              rdData <= '0;
    else if (strobes.rdStb) rdData <= rdNext;
  end
endmodule

// File: rtl/chanRegBank.sv
module chanRegBank
  import chanRegPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  regStrobes_t strobes;

  chanRegCtrl i_ctrl (
    .wrEn    (wrEn),
    .rdEn    (rdEn),
    .addr    (addr),
    .strobes (strobes)
  );

  chanRegData i_data (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .wrData  (wrData),
    .rdData  (rdData)
  );
endmodule

// File: rtl/chanRegBankChk.sv
module chanRegBankChk
  import chanRegPkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic              rdEn,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] rdData
);
  function automatic logic isMapped(input logic [ADDR_W-1:0] a);
    logic hit;
    hit = (a == IDX_ADDR);
    for (int g = 0; g < NUM_GLB; g++) if (a == GLB_ADDR[g]) hit = 1'b1;
    for (int l = 0; l < NUM_LOC; l++) if (a == LOC_ADDR[l]) hit = 1'b1;
    return hit;
  endfunction

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdData));

  assert_idx_unused_R3: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == IDX_ADDR) |=> (rdData[DATA_W-1:NUM_CH] == '0));

  assert_global_copy_R6: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !rdEn && addr == GLB_ADDR[0]) ##1 (rdEn && !wrEn && addr == GLB_ADDR[0])
    |=> (rdData == ($past(wrData, 2) & GLB_MASK[0])));

  assert_local_mask_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == LOC_ADDR[0]) |=> ((rdData & ~LOC_MASK[0]) == '0));

  assert_unmapped_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !isMapped(addr)) |=> (rdData == '0));
endmodule

bind chanRegBank chanRegBankChk i_chk (
  .clk    (clk),
  .rstN   (rstN),
  .wrEn   (wrEn),
  .rdEn   (rdEn),
  .addr   (addr),
  .wrData (wrData),
  .rdData (rdData)
);

// File: tb/test_chanRegBank.sv
module test_chanRegBank;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic       rdEn = 1'b0;
  logic [9:0] addr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] expQ [$];
  string      tagQ [$];

  always #2 clk = ~clk;

  chanRegBank i_chanRegBank (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wrData(wrData), .rdData(rdData)
  );

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [9:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic regRead(input logic [9:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    expQ.push_back(exp);
    tagQ.push_back(tag);
    rdEn = 1'b1; addr = a;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  // monitor: a read sampled on this edge is visible at the next falling edge
  always @(posedge clk) begin
    if (rstN && rdEn) begin
      @(negedge clk);
      if (expQ.size() == 0) begin
        check(8'hEE, 8'h00, "scoreboard underflow");
      end else begin
        check(rdData, expQ.pop_front(), tagQ.pop_front());
      end
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(rdData, 8'h00, "R2 output after reset");

    // R1 defaults (index still 0x3F, local reads fall back to A)
    regRead(10'h005, 8'h3F, "R1 R3 index default");
    regRead(10'h00D, 8'h00, "R1 local 0x00D default");
    regRead(10'h014, 8'h01, "R1 local 0x014 default");
    regRead(10'h100, 8'h05, "R1 local 0x100 default");
    regRead(10'h008, 8'h00, "R1 global 0x008 default");
    regRead(10'h109, 8'h02, "R1 global 0x109 default");
    regWrite(10'h005, 8'h20);
    regRead(10'h100, 8'h05, "R1 data-clock copy default");

    // R4 broadcast to all six copies
    regWrite(10'h005, 8'h3F);
    regWrite(10'h014, 8'hA5);
    for (int c = 0; c < 6; c++) begin
      regWrite(10'h005, 8'(1 << c));
      regRead(10'h014, 8'hA5, $sformatf("R4 broadcast reached channel %0d", c));
    end

    // R4 single channel B write, others untouched
    regWrite(10'h005, 8'h02);
    regWrite(10'h014, 8'h3C);
    regWrite(10'h005, 8'h01);
    regRead(10'h014, 8'hA5, "R4 channel A untouched");
    regWrite(10'h005, 8'h02);
    regRead(10'h014, 8'h3C, "R4 channel B written");
    regWrite(10'h005, 8'h04);
    regRead(10'h014, 8'hA5, "R4 channel C untouched");

    // R4 clock channels only
    regWrite(10'h005, 8'h30);
    regWrite(10'h014, 8'h77);
    regWrite(10'h005, 8'h10);
    regRead(10'h014, 8'h77, "R4 frame-clock copy written");
    regWrite(10'h005, 8'h20);
    regRead(10'h014, 8'h77, "R4 data-clock copy written");
    regWrite(10'h005, 8'h08);
    regRead(10'h014, 8'hA5, "R4 channel D untouched");

    // R5 fallback to channel A
    regWrite(10'h005, 8'h06);
    regRead(10'h014, 8'hA5, "R5 two bits set returns A");
    regWrite(10'h005, 8'h00);
    regRead(10'h014, 8'hA5, "R5 no bit set returns A");
    regWrite(10'h005, 8'h3E);
    regRead(10'h014, 8'hA5, "R5 many bits set returns A");

    // R3 R7 index unused bits
    regWrite(10'h005, 8'hFF);
    regRead(10'h005, 8'h3F, "R3 index bits 7:6 read 0");
    regWrite(10'h005, 8'hC1);
    regRead(10'h005, 8'h01, "R3 index write masked");

    // R6 globals ignore the index
    regWrite(10'h008, 8'h5A);
    regWrite(10'h005, 8'h02);
    regRead(10'h008, 8'h5A, "R6 global read ignores index");
    regWrite(10'h005, 8'h00);
    regWrite(10'h109, 8'hFF);
    regWrite(10'h005, 8'h30);
    regRead(10'h109, 8'h07, "R6 R7 global write with empty index, masked");

    // R7 local masks
    regWrite(10'h005, 8'h3F);
    regWrite(10'h00D, 8'hFF);
    regWrite(10'h100, 8'hFF);
    regWrite(10'h005, 8'h04);
    regRead(10'h00D, 8'h3F, "R7 local 0x00D field 5:0");
    regRead(10'h100, 8'h0F, "R7 local 0x100 field 3:0");

    // R8 unmapped addresses
    regWrite(10'h013, 8'h55);
    regRead(10'h013, 8'h00, "R8 unmapped 0x013 reads 0");
    regWrite(10'h3FF, 8'h55);
    regRead(10'h3FF, 8'h00, "R8 unmapped 0x3FF reads 0");
    regWrite(10'h205, 8'h01);
    regRead(10'h005, 8'h04, "R8 alias write left index alone");
    regWrite(10'h114, 8'h00);
    regRead(10'h014, 8'hA5, "R8 alias write left local alone");

    // R2 hold while idle
    regRead(10'h109, 8'h07, "R2 read before idle");
    repeat (3) @(negedge clk);
    check(rdData, 8'h07, "R2 output held without read");
    regWrite(10'h109, 8'h01);
    @(negedge clk);
    check(rdData, 8'h07, "R2 output held across write");

    repeat (2) @(negedge clk);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual 0x00 expected 0x01");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule